// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one 16-bit timer channel for a peripheral subsystem. A prescaled up-counter runs while this channel's bit in a shared run register is set. Two general registers, A and B, each act either as a compare register that drives an output pin on a match, or as a capture register that latches the counter on an edge of an input pin. Compare matches, captures and counter overflow set status flags. The A and B flags can raise one interrupt request. Software reaches every register through a byte-addressed bus with a 16-bit data path. Eight-bit registers use the low byte of that path.

Run control is a three-state machine with the states STOPPED, COUNTING and HALTED. STOPPED goes to COUNTING on START, when the run bit is set and the prescaler code is valid. STOPPED goes to HALTED on START_RESERVED, when the run bit is set and the code is reserved. COUNTING goes to STOPPED on RUN_OFF when the run bit clears, and to HALTED on CODE_RESERVED when a reserved code is written. HALTED goes to STOPPED on RUN_OFF and back to COUNTING on CODE_VALID. The prescaler divider is held at zero in every state except COUNTING, so each entry into COUNTING restarts the division.

Register offsets: control 0, mode 1, I/O control 2, interrupt enable 4, status 5, counter 6, general A 8, general B 10, run register 12.

Top module: `cmt_channel`

## Requirements
- R1: After reset every register reads 0, both pins are 0 and the interrupt request is 0.
- R2: Control, mode, I/O control and interrupt enable store and return the low 8 bits of a write. The counter and the general registers store 16 bits. The run register keeps one bit per channel. Offsets that hold no register read as 0.
- R3: The counter advances only while run-register bit CH_IDX is 1. The other bits have no effect on this channel. Clearing the bit freezes the count at its current value.
- R4: Control bits 2:0 select the prescaler. Code 0 gives one count per clock, 1 one count every 4 clocks, 2 every 16 and 3 every 64. Codes 4 to 7 stop counting. The divider restarts each time counting resumes.
- R5: Control bits 7:5 select the clear source. Code 1 returns the counter to 0 on the count after it equals A, which gives a period of A+1 counts. Code 2 does the same with B. Any other code never clears. Clearing applies only while that register is in compare mode.
- R6: Each I/O nibble (bits 3:0 for pin A, bits 7:4 for pin B) picks a pin action. Writing code 1, 2 or 3 loads the pin with 0, and writing code 5, 6 or 7 loads it with 1. On each compare match, codes 1 and 5 drive the pin low, 2 and 6 drive it high, and 3 and 7 toggle it. Codes 0 and 4 leave the pin unchanged.
- R7: I/O code 8, 9 or 10 makes the general register capture the counter on a rising, falling or either edge of its cap_in bit. Capture sets the same flag as a match.
- R8: Status bit 0 sets on a match or capture of A, bit 1 on one of B, and bit 4 when the counter rolls over from 0xFFFF to 0.
- R9: The interrupt request is high while status bit 0 is set with enable bit 0, or status bit 1 is set with enable bit 1.
- R10: A status write clears a flag only where the written bit is 0 and the flag was read as 1 since the last status write. Writing 1 has no effect. A set event in the same cycle as a clear keeps the flag set.
- R11: A counter write in a cycle takes priority over counting, clearing, matching and overflow in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, used to arm flag clearing |
| bus_rdata | output | DW | Read data for bus_addr |
| cap_in | input | 2 | Capture inputs, bit 0 for A and bit 1 for B |
| pin_out | output | 2 | Compare output pins, bit 0 for A and bit 1 for B |
| irq_out | output | 1 | Interrupt request |

## Verification
Periodic counting is run at every prescaler code, with clearing on A, on B and on neither, including a reserved code and the run bit dropping mid-count. This separates a wrong divide ratio or divider restart from a wrong clear point. Pin actions are tried with both start levels and both edges of a match. Captures are driven with rising-only, falling-only and both-edge codes, so that each edge sensitivity is told apart. Flag clearing is tried without a prior read, with a mask that clears a single flag, and in a tight read-then-clear loop against a short period, so that set-versus-clear collisions happen. A behavioural model compares the read data, the pins and the request on every cycle.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic [1:0] {
        RS_STOPPED  = 2'd0,
        RS_COUNTING = 2'd1,
        RS_HALTED   = 2'd2
    } run_state_e;

    localparam int OFS_CTRL   = 0;
    localparam int OFS_MODE   = 1;
    localparam int OFS_IOCTL  = 2;
    localparam int OFS_INTEN  = 4;
    localparam int OFS_STATUS = 5;
    localparam int OFS_COUNT  = 6;
    localparam int OFS_GEN_A  = 8;
    localparam int OFS_GEN_B  = 10;
    localparam int OFS_START  = 12;

    localparam logic [2:0] CLR_ON_A = 3'd1;
    localparam logic [2:0] CLR_ON_B = 3'd2;

    localparam int NUM_GR       = 2;
    localparam int NUM_FLAGS    = 3;
    localparam int FLAG_BIT_OVF = 4;

    // codes 0..7 are compare codes, 8 and up are capture or unused
    function automatic logic io_is_compare(input logic [3:0] code);
        return !code[3];
    endfunction

    // compare codes that load a start level when written
    function automatic logic io_loads_level(input logic [3:0] code);
        return !code[3] && (code[1:0] != 2'b00);
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       tick
);

    run_state_e         state_q, state_d;
    logic [DIV_W-1:0]   div_q;
    logic [DIV_W:0]     lim_w;
    logic [DIV_W-1:0]   lim;
    logic               valid;

    assign valid = !sel[2];
    assign lim_w = ((DIV_W+1)'(1) << {sel[1:0], 1'b0}) - (DIV_W+1)'(1);
    assign lim   = lim_w[DIV_W-1:0];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_STOPPED: begin
                if (run) state_d = valid ? RS_COUNTING : RS_HALTED;
            end
            RS_COUNTING: begin
                if (!run)        state_d = RS_STOPPED;
                else if (!valid) state_d = RS_HALTED;
            end
            RS_HALTED: begin
                if (!run)       state_d = RS_STOPPED;
                else if (valid) state_d = RS_COUNTING;
            end
            default: state_d = RS_STOPPED;
        endcase
    end

    // outputs
    always_comb begin
        tick = (state_q == RS_COUNTING) && run && valid && (div_q >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if ((state_q == RS_COUNTING) && run && valid) begin
            div_q <= tick ? '0 : div_q + 1'b1;
        end else begin
            div_q <= '0;
        end
    end

    a_r3_no_tick_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

    a_r4_restart_no_early_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> !tick);

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter
    import cmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [2:0]   clr_sel,
    input  logic [1:0]   cmp_ok,
    input  logic [W-1:0] gr_a,
    input  logic [W-1:0] gr_b,
    output logic [W-1:0] cnt,
    output logic         step,
    output logic         ovf
);

    logic clr;

    assign step = tick && !wr_en;

    always_comb begin
        clr = 1'b0;
        if (step) begin
            if (clr_sel == CLR_ON_A && cmp_ok[0] && cnt == gr_a) clr = 1'b1;
            if (clr_sel == CLR_ON_B && cmp_ok[1] && cnt == gr_b) clr = 1'b1;
        end
        ovf = step && (&cnt) && !clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_en) begin
            cnt <= wr_data;
        end else if (step) begin
            cnt <= clr ? '0 : cnt + 1'b1;
        end
    end

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cnt == $past(wr_data));

    a_r3_frozen_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(cnt));

    a_r5_clear_on_a: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && clr_sel == CLR_ON_A && cmp_ok[0] && cnt == gr_a) |=> cnt == '0);

endmodule

// File: rtl/cmt_gr_unit.sv
module cmt_gr_unit
    import cmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   code,
    input  logic         load,
    input  logic [3:0]   load_code,
    input  logic         step,
    input  logic [W-1:0] cnt,
    input  logic         cap,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] gr,
    output logic         event_o,
    output logic         pin
);

    logic prev_q;
    logic rise, fall, cap_hit, match;

    always_comb begin
        rise    = cap && !prev_q;
        fall    = !cap && prev_q;
        cap_hit = ((code == 4'd8) && rise) ||
                  ((code == 4'd9) && fall) ||
                  ((code == 4'd10) && (rise || fall));
        match   = io_is_compare(code) && step && (cnt == gr);
        event_o = match || cap_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            gr     <= '0;
        end else begin
            prev_q <= cap;
            if (wr_en)        gr <= wr_data;
            else if (cap_hit) gr <= cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (load && io_loads_level(load_code)) begin
            pin <= load_code[2];
        end else if (match) begin
            unique case (code[1:0])
                2'd1:    pin <= 1'b0;
                2'd2:    pin <= 1'b1;
                2'd3:    pin <= !pin;
                default: pin <= pin;
            endcase
        end
    end

    a_r6_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !match) |=> $stable(pin));

    a_r7_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_hit && !wr_en) |=> gr == $past(cnt));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DW     = 16,
    parameter int AW     = 4,
    parameter int NUM_CH = 3,
    parameter int CH_IDX = 0,
    parameter int DIV_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_we,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NUM_GR-1:0] cap_in,
    output logic [NUM_GR-1:0] pin_out,
    output logic              irq_out
);

    logic [7:0]        ctrl_q, mode_q, io_q, ie_q;
    logic [NUM_CH-1:0] start_q;
    logic              wr_ctrl, wr_mode, wr_io, wr_ie, wr_status, wr_count, wr_start;
    logic              rd_status;
    logic              tick, step, ovf;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  gr_val [NUM_GR];
    logic [NUM_GR-1:0] gr_event;
    logic [NUM_GR-1:0] cmp_ok;
    logic [NUM_FLAGS-1:0] flag_q, arm_q, set_vec;

    always_comb begin
        wr_ctrl   = bus_we && (bus_addr == AW'(OFS_CTRL));
        wr_mode   = bus_we && (bus_addr == AW'(OFS_MODE));
        wr_io     = bus_we && (bus_addr == AW'(OFS_IOCTL));
        wr_ie     = bus_we && (bus_addr == AW'(OFS_INTEN));
        wr_status = bus_we && (bus_addr == AW'(OFS_STATUS));
        wr_count  = bus_we && (bus_addr == AW'(OFS_COUNT));
        wr_start  = bus_we && (bus_addr == AW'(OFS_START));
        rd_status = bus_rd && (bus_addr == AW'(OFS_STATUS));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mode_q  <= '0;
            io_q    <= '0;
            ie_q    <= '0;
            start_q <= '0;
        end else begin
            if (wr_ctrl)  ctrl_q  <= bus_wdata[7:0];
            if (wr_mode)  mode_q  <= bus_wdata[7:0];
            if (wr_io)    io_q    <= bus_wdata[7:0];
            if (wr_ie)    ie_q    <= bus_wdata[7:0];
            if (wr_start) start_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    cmt_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (start_q[CH_IDX]),
        .sel   (ctrl_q[2:0]),
        .tick  (tick)
    );

    cmt_counter #(.W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_count),
        .wr_data (bus_wdata[CNT_W-1:0]),
        .clr_sel (ctrl_q[7:5]),
        .cmp_ok  (cmp_ok),
        .gr_a    (gr_val[0]),
        .gr_b    (gr_val[1]),
        .cnt     (cnt),
        .step    (step),
        .ovf     (ovf)
    );

    for (genvar g = 0; g < NUM_GR; g++) begin : g_gr
        logic gr_wr;
        assign gr_wr     = bus_we && (bus_addr == AW'(OFS_GEN_A + 2 * g));
        assign cmp_ok[g] = io_is_compare(io_q[4*g +: 4]);

        cmt_gr_unit #(.W(CNT_W)) u_gr (
            .clk       (clk),
            .rst_n     (rst_n),
            .code      (io_q[4*g +: 4]),
            .load      (wr_io),
            .load_code (bus_wdata[4*g +: 4]),
            .step      (step),
            .cnt       (cnt),
            .cap       (cap_in[g]),
            .wr_en     (gr_wr),
            .wr_data   (bus_wdata[CNT_W-1:0]),
            .gr        (gr_val[g]),
            .event_o   (gr_event[g]),
            .pin       (pin_out[g])
        );
    end

    assign set_vec = {ovf, gr_event[1], gr_event[0]};

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        localparam int POS = (k == NUM_FLAGS - 1) ? FLAG_BIT_OVF : k;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[k] <= 1'b0;
                arm_q[k]  <= 1'b0;
            end else begin
                if (set_vec[k])
                    flag_q[k] <= 1'b1;
                else if (wr_status && arm_q[k] && !bus_wdata[POS])
                    flag_q[k] <= 1'b0;

                if (wr_status)
                    arm_q[k] <= 1'b0;
                else if (rd_status && flag_q[k])
                    arm_q[k] <= 1'b1;
            end
        end

        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[k] |=> flag_q[k]);

        a_r10_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[k] && !arm_q[k]) |=> flag_q[k]);
    end

    assign irq_out = |(flag_q[1:0] & ie_q[1:0]);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFS_CTRL):   bus_rdata[7:0] = ctrl_q;
            AW'(OFS_MODE):   bus_rdata[7:0] = mode_q;
            AW'(OFS_IOCTL):  bus_rdata[7:0] = io_q;
            AW'(OFS_INTEN):  bus_rdata[7:0] = ie_q;
            AW'(OFS_STATUS): begin
                bus_rdata[0]            = flag_q[0];
                bus_rdata[1]            = flag_q[1];
                bus_rdata[FLAG_BIT_OVF] = flag_q[2];
            end
            AW'(OFS_COUNT):  bus_rdata[CNT_W-1:0]  = cnt;
            AW'(OFS_GEN_A):  bus_rdata[CNT_W-1:0]  = gr_val[0];
            AW'(OFS_GEN_B):  bus_rdata[CNT_W-1:0]  = gr_val[1];
            AW'(OFS_START):  bus_rdata[NUM_CH-1:0] = start_q;
            default:         bus_rdata = '0;
        endcase
    end

    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q[1:0] == 2'b00) |-> !irq_out);

endmodule

// File: tb/test_cmt_channel.sv
`timescale 1ns/1ps
module test_cmt_channel;

    localparam int CH  = 1;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  baddr = '0;
    logic [15:0] bwdata = '0;
    logic        bwe = 1'b0;
    logic        brd = 1'b0;
    logic [1:0]  cap = '0;
    logic [15:0] rdata;
    logic [1:0]  pins;
    logic        irq;

    always #2.5 clk = ~clk;

    cmt_channel #(.NUM_CH(NCH), .CH_IDX(CH)) i_cmt_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (baddr),
        .bus_wdata (bwdata),
        .bus_we    (bwe),
        .bus_rd    (brd),
        .bus_rdata (rdata),
        .cap_in    (cap),
        .pin_out   (pins),
        .irq_out   (irq)
    );

    int    errors = 0;
    int    checks = 0;
    string tag = "R1";
    bit    done = 0;

    // behavioural reference model
    int m_ctrl, m_mode, m_io, m_ie, m_start, m_state, m_div, m_cnt;
    int m_gr [2];
    bit m_pin [2];
    bit m_prev [2];
    bit m_flag [3];
    bit m_arm [3];
    int fpos [3] = '{0, 1, 4};

    function automatic int mread(int a);
        case (a)
            0:  return m_ctrl;
            1:  return m_mode;
            2:  return m_io;
            4:  return m_ie;
            5:  return int'(m_flag[0]) | (int'(m_flag[1]) << 1) | (int'(m_flag[2]) << 4);
            6:  return m_cnt;
            8:  return m_gr[0];
            10: return m_gr[1];
            12: return m_start;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        int psel, lim, clrs, nc, ncnt, nstate, ndiv;
        int code [2];
        int ngr [2];
        bit runb, valid, tick, cntw, stp, clr, ovf, rise, fall, stwr;
        bit match [2];
        bit caph [2];
        bit ev [3];
        bit npin [2];
        bit nflag [3];
        bit narm [3];
        if (!rst_n) begin
            m_ctrl = 0; m_mode = 0; m_io = 0; m_ie = 0; m_start = 0;
            m_state = 0; m_div = 0; m_cnt = 0;
            for (int g = 0; g < 2; g++) begin
                m_gr[g] = 0; m_pin[g] = 0; m_prev[g] = 0;
            end
            for (int k = 0; k < 3; k++) begin
                m_flag[k] = 0; m_arm[k] = 0;
            end
        end else begin
            psel  = m_ctrl & 7;
            valid = psel < 4;
            lim   = (1 << (2 * (psel & 3))) - 1;
            runb  = ((m_start >> CH) & 1) == 1;
            tick  = (m_state == 1) && runb && valid && (m_div >= lim);
            cntw  = bwe && baddr == 6;
            stp   = tick && !cntw;
            stwr  = bwe && baddr == 5;
            for (int g = 0; g < 2; g++) begin
                code[g]  = (m_io >> (4 * g)) & 15;
                match[g] = code[g] < 8 && stp && m_cnt == m_gr[g];
                rise     = cap[g] && !m_prev[g];
                fall     = !cap[g] && m_prev[g];
                caph[g]  = (code[g] == 8 && rise) || (code[g] == 9 && fall) ||
                           (code[g] == 10 && (rise || fall));
                ev[g]    = match[g] || caph[g];
            end
            clrs = (m_ctrl >> 5) & 7;
            clr  = stp && ((clrs == 1 && code[0] < 8 && m_cnt == m_gr[0]) ||
                           (clrs == 2 && code[1] < 8 && m_cnt == m_gr[1]));
            ovf  = stp && m_cnt == 65535 && !clr;
            ev[2] = ovf;
            ncnt = cntw ? int'(bwdata) : (stp ? (clr ? 0 : (m_cnt + 1) & 65535) : m_cnt);
            for (int g = 0; g < 2; g++) begin
                if (bwe && baddr == 8 + 2 * g) ngr[g] = int'(bwdata);
                else if (caph[g])              ngr[g] = m_cnt;
                else                           ngr[g] = m_gr[g];
                nc = (int'(bwdata) >> (4 * g)) & 15;
                npin[g] = m_pin[g];
                if (bwe && baddr == 2 && nc >= 1 && nc <= 3)      npin[g] = 0;
                else if (bwe && baddr == 2 && nc >= 5 && nc <= 7) npin[g] = 1;
                else if (match[g]) begin
                    if ((code[g] & 3) == 1)      npin[g] = 0;
                    else if ((code[g] & 3) == 2) npin[g] = 1;
                    else if ((code[g] & 3) == 3) npin[g] = !m_pin[g];
                end
            end
            for (int k = 0; k < 3; k++) begin
                nflag[k] = m_flag[k];
                if (ev[k]) nflag[k] = 1;
                else if (stwr && m_arm[k] && !bwdata[fpos[k]]) nflag[k] = 0;
                narm[k] = m_arm[k];
                if (stwr) narm[k] = 0;
                else if (brd && baddr == 5 && m_flag[k]) narm[k] = 1;
            end
            nstate = m_state;
            case (m_state)
                0: if (runb) nstate = valid ? 1 : 2;
                1: if (!runb) nstate = 0; else if (!valid) nstate = 2;
                default: if (!runb) nstate = 0; else if (valid) nstate = 1;
            endcase
            ndiv = ((m_state == 1) && runb && valid) ? (tick ? 0 : m_div + 1) : 0;
            if (bwe && baddr == 0)  m_ctrl  = int'(bwdata[7:0]);
            if (bwe && baddr == 1)  m_mode  = int'(bwdata[7:0]);
            if (bwe && baddr == 2)  m_io    = int'(bwdata[7:0]);
            if (bwe && baddr == 4)  m_ie    = int'(bwdata[7:0]);
            if (bwe && baddr == 12) m_start = int'(bwdata[NCH-1:0]);
            m_state = nstate; m_div = ndiv; m_cnt = ncnt;
            for (int g = 0; g < 2; g++) begin
                m_gr[g] = ngr[g]; m_pin[g] = npin[g]; m_prev[g] = cap[g];
            end
            for (int k = 0; k < 3; k++) begin
                m_flag[k] = nflag[k]; m_arm[k] = narm[k];
            end
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (rst_n && !done) begin
            check("rdata", int'(rdata), mread(int'(baddr)));
            check("pin_a", int'(pins[0]), int'(m_pin[0]));
            check("pin_b", int'(pins[1]), int'(m_pin[1]));
            check("irq", int'(irq), int'((m_flag[0] && (m_ie & 1)) || (m_flag[1] && (m_ie & 2))));
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(int a, int d);
        baddr = 4'(a); bwdata = 16'(d); bwe = 1'b1;
        step();
        bwe = 1'b0;
    endtask

    task automatic rd(int a);
        baddr = 4'(a); brd = 1'b1;
        step();
        brd = 1'b0;
    endtask

    task automatic rd_expect(int a, int exp);
        rd(a);
        check("readback", int'(rdata), exp);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog (all R): actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin : stimulus
        int v1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        tag = "R1";
        check("pins after reset", int'(pins), 0);
        check("irq after reset", int'(irq), 0);
        for (int a = 0; a < 14; a++) rd_expect(a, 0);

        // R2: register access
        tag = "R2";
        wr(0, 16'hFF3C); rd_expect(0, 16'h003C);
        wr(1, 16'h005A); rd_expect(1, 16'h005A);
        wr(2, 16'h0044); rd_expect(2, 16'h0044);
        wr(4, 16'hA513); rd_expect(4, 16'h0013);
        wr(8, 16'h1234); rd_expect(8, 16'h1234);
        wr(10, 16'hBEEF); rd_expect(10, 16'hBEEF);
        wr(6, 16'h00FF); rd_expect(6, 16'h00FF);
        wr(12, 16'h00FF); rd_expect(12, 16'h0007);
        wr(12, 0);
        rd_expect(3, 0); rd_expect(7, 0); rd_expect(14, 0);
        wr(0, 0); wr(2, 0); wr(4, 0); wr(6, 0);

        // R5: clear sources
        tag = "R5";
        wr(8, 5); wr(10, 3); wr(0, 16'h20); wr(12, 1 << CH);
        idle(25);
        wr(0, 16'h40); idle(20);
        wr(0, 16'h60); idle(12);
        wr(0, 16'h20); wr(6, 0); idle(10);

        // R4: prescaler codes
        tag = "R4";
        wr(8, 3); wr(0, 16'h21); idle(40);
        wr(0, 16'h23); idle(300);
        wr(0, 16'h22); idle(80);
        wr(0, 16'h26); rd(6); v1 = int'(rdata); idle(8); rd(6);
        check("reserved code holds count", int'(rdata), v1);
        wr(0, 16'h21); idle(12);

        // R3: run bit gating
        tag = "R3";
        wr(0, 16'h20);
        wr(12, 5); rd(6); v1 = int'(rdata); idle(6); rd(6);
        check("frozen count", int'(rdata), v1);
        wr(12, 1 << CH); idle(10);

        // R11 and R8: counter write and overflow
        tag = "R11";
        wr(6, 2); idle(3);
        wr(0, 0); wr(6, 16'hFFFD); idle(6);
        tag = "R8";
        wr(12, 0); idle(2);

        // R10: flag clearing rules
        tag = "R10";
        wr(5, 0); rd(5);
        check("overflow flag kept without read", int'(rdata[4]), 1);
        wr(5, 16'hFFFF); rd(5);
        check("overflow flag kept on write one", int'(rdata[4]), 1);
        wr(5, 16'hFFEF); rd(5);
        check("overflow flag cleared", int'(rdata[4]), 0);
        wr(8, 1); wr(0, 16'h20); wr(12, 1 << CH);
        for (int i = 0; i < 20; i++) begin
            rd(5); wr(5, 0);
        end

        // R9: interrupt gating
        tag = "R9";
        wr(4, 1); idle(10); rd(5); wr(5, 0);
        wr(4, 2); wr(10, 0); wr(0, 16'h40); idle(10);
        wr(4, 3); idle(10);
        wr(4, 0); idle(4);

        // R6: pin actions
        tag = "R6";
        wr(12, 0); wr(6, 0); wr(8, 4); wr(10, 9);
        wr(2, 16'h53); wr(0, 16'h40); wr(12, 1 << CH); idle(40);
        wr(2, 16'h27); idle(30);
        wr(2, 16'h61); idle(30);
        wr(2, 16'h00); idle(12);

        // R7: input capture
        tag = "R7";
        wr(4, 3); wr(0, 16'h01); wr(2, 16'hA8);
        for (int i = 0; i < 6; i++) begin
            cap[0] = ~cap[0]; idle(5);
            cap[1] = ~cap[1]; idle(7);
        end
        rd(5); wr(5, 0);
        wr(2, 16'h09);
        for (int i = 0; i < 4; i++) begin
            cap[0] = ~cap[0]; idle(6);
        end
        wr(2, 16'h0A);
        for (int i = 0; i < 4; i++) begin
            cap[0] = ~cap[0]; idle(6);
        end
        idle(4);

        done = 1;
        summary();
        $finish;
    end

endmodule